// File: doc/BRIEF.md
# Video Adapter Host Register Interface

This block is the host-facing register file of a video capture and display adapter. A host reaches sixteen byte-wide register slots through an address bus. A strap input picks the address layout. In the packed layout the slots occupy sixteen consecutive addresses. In the sparse layout they form four groups of four, with the groups spaced 0x400 apart. A read and a write to the same slot usually reach different registers. Several write-only registers are read back at a different slot. Two read slots exist only for their side effect, which selects the scan mode.

A further bank of up to 16-bit advanced registers sits behind an index-plus-data pair. The host writes an 8-bit index to one slot and then moves 16-bit data through another slot. Five advanced indices are second views of the border color bytes and the video control byte. The block also latches vertical blanking events into a flag that is cleared when it is read. It drives every stored register out to the video datapath.

Top module: `vidreg_hostif`

## Requirements
- R1: With `strap_packed`=1, slot n (0..15) decodes at address n. Any address with a bit set above bit 3 is a miss. A miss write changes nothing, and a miss read returns 0.
- R2: With `strap_packed`=0, slot n decodes at address {n[3:2], 8'b0, n[1:0]}. Any other address is a miss, with the same miss behaviour as R1.
- R3: Write slots 0–3 load border color bytes 0–3 (`border_color` bits 7:0 up to 31:24). A read of slot 0 returns {6'b0, `no_sync`, `field_odd`}, not the color.
- R4: The mask-low byte written at slot 8 reads back at slot 3. The bank-low byte written at slot 10 reads back at slot 4. Mode-1 written at slot 12 reads back at slot 6. Slots 7, 9, 11 and 13 read back what was written to them.
- R5: A read of slot 1 returns {MEM_CFG[3:0], VERSION[2:0], vblank flag}. The flag is set by a `vblank_evt` pulse and cleared by a read of slot 1. If a pulse and a read fall in the same cycle, the read returns the old flag and the flag ends up set.
- R6: A read of slot 8 clears `overscan` and a read of slot 10 sets it. Both reads return 0. `overscan` resets to 0 and changes only on these two reads.
- R7: A write to slot 5 loads the 8-bit index. Slot 14 then moves 16-bit data to and from advanced register index 0x40+k (k < ADV_N). When mode-1 bit 6 is set, slot 14 writes are ignored and slot 14 reads return 0.
- R8: Advanced slots k=0..7 are 11, 9, 16, 10, 11, 10, 9 and 11 bits wide. Upper bits read as 0, and writes to those bits are discarded.
- R9: Advanced indices 0xE0–0xE3 reach border color bytes 0–3, and index 0xE4 reaches the video control byte. These accesses use the low 8 data bits, and their upper read bits are 0.
- R10: A read of slot 5 returns `adv_active` in bit 3 and 0 in every other bit.
- R11: `bus_rdata` and `rd_valid` update one cycle after a `bus_rd` strobe. `rd_valid` is low in every cycle that does not follow a read.
- R12: After reset every stored register, the index, `overscan` and the vblank flag are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_packed | input | 1 | 1: packed decode, 0: sparse decode |
| bus_addr | input | ADDR_W | Host address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 16 | Write data; byte slots use bits 7:0 |
| bus_rdata | output | 16 | Registered read data |
| rd_valid | output | 1 | High the cycle after a read |
| vblank_evt | input | 1 | Vertical blanking event pulse |
| field_odd | input | 1 | Odd field being displayed |
| no_sync | input | 1 | No external sync detected |
| adv_active | input | 1 | Advanced operating mode active |
| row_count | input | 8 | Current display line, read at slot 12 |
| border_color | output | 32 | Border color bytes |
| vid_ctl | output | 8 | Video control byte |
| hue_sat | output | 8 | Hue/saturation byte |
| ov_start | output | 8 | Overlay start byte |
| wr_mask | output | 16 | Write protect mask {high, low} |
| bank_lo | output | 8 | Lower window bank |
| bank_hi | output | 8 | Upper window bank |
| mode1 | output | 8 | Mode-1 byte |
| mode2 | output | 8 | Mode-2 byte |
| overscan | output | 1 | 1: overscan, 0: underscan |
| adv_regs | output | 16*ADV_N | Advanced registers, slot k at bits 16k+15:16k |

## Verification
Each write slot is loaded with a distinct byte and then read at its alias slot and at its own slot. This separates a correct alias from a same-slot readback and from a swapped decode. The same slot is also reached under both straps, and through addresses that belong only to the other layout. These misses show that a decode does not leak into the other layout's address space. The advanced port is driven with all-ones data across slots of different widths, which exposes any wrong width mask. It is also driven with the selector bit set, which shows whether the write path is gated. The vblank flag is exercised with an isolated pulse, with a back-to-back read, and with a pulse that coincides with a read. Together these separate set priority from clear priority.

// File: rtl/vidreg_pkg.sv
package vidreg_pkg;

    localparam int SLOT_W = 4;
    typedef logic [SLOT_W-1:0] slot_t;

    // host slot numbers whose position is decoded elsewhere
    localparam slot_t S_STAT0  = 4'd0;
    localparam slot_t S_STAT1  = 4'd1;
    localparam slot_t S_MASKLR = 4'd3;
    localparam slot_t S_BANKLR = 4'd4;
    localparam slot_t S_INDEX  = 4'd5;
    localparam slot_t S_MODE1R = 4'd6;
    localparam slot_t S_OVST   = 4'd7;
    localparam slot_t S_MASKL  = 4'd8;
    localparam slot_t S_MASKH  = 4'd9;
    localparam slot_t S_BANKL  = 4'd10;
    localparam slot_t S_BANKH  = 4'd11;
    localparam slot_t S_MODE1  = 4'd12;
    localparam slot_t S_MODE2  = 4'd13;
    localparam slot_t S_DATA   = 4'd14;

    localparam logic [7:0] ADV_BASE   = 8'h40;
    localparam logic [7:0] ALIAS_BASE = 8'hE0;
    localparam logic [7:0] ALIAS_N    = 8'd5;
    localparam int         SEL_BIT    = 6;

    typedef struct packed {
        logic  hit;
        slot_t slot;
    } dec_t;

    typedef struct packed {
        logic [3:0][7:0] color;
        logic [7:0]      vidctl;
        logic [7:0]      huesat;
        logic [7:0]      ovst;
        logic [7:0]      maskl;
        logic [7:0]      maskh;
        logic [7:0]      bankl;
        logic [7:0]      bankh;
        logic [7:0]      mode1;
        logic [7:0]      mode2;
    } host_regs_t;

    function automatic logic [15:0] adv_mask(input int unsigned k);
        int unsigned w;
        case (k)
            0: w = 11;
            1: w = 9;
            2: w = 16;
            3: w = 10;
            4: w = 11;
            5: w = 10;
            6: w = 9;
            7: w = 11;
            default: w = 16;
        endcase
        adv_mask = 16'((32'd1 << w) - 32'd1);
    endfunction

endpackage

// File: rtl/vidreg_decode.sv
module vidreg_decode
    import vidreg_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int GRP_SHIFT = 10
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              packed_mode,
    output dec_t              dec
);
    localparam logic [ADDR_W-1:0] PK_KEEP = ADDR_W'(15);
    localparam logic [ADDR_W-1:0] SP_KEEP = ADDR_W'(3) | (ADDR_W'(3) << GRP_SHIFT);

    always_comb begin
        if (packed_mode) begin
            dec.hit  = (addr & ~PK_KEEP) == '0;
            dec.slot = addr[3:0];
        end else begin
            dec.hit  = (addr & ~SP_KEEP) == '0;
            dec.slot = {addr[GRP_SHIFT+1:GRP_SHIFT], addr[1:0]};
        end
    end
endmodule

// File: rtl/vidreg_advbank.sv
module vidreg_advbank
    import vidreg_pkg::*;
#(
    parameter int ADV_N = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [7:0]        idx,
    input  logic [15:0]       wdata,
    output logic [ADV_N*16-1:0] regs,
    output logic [15:0]       rdata
);
    logic [7:0] off;
    assign off = idx - ADV_BASE;

    for (genvar k = 0; k < ADV_N; k++) begin : g_slot
        localparam logic [15:0] MSK = adv_mask(k);
        logic [15:0] r;
        always_ff @(posedge clk) begin
            if (rst)                          r <= '0;
            else if (wr_en && off == 8'(k))   r <= wdata & MSK;
        end
        assign regs[k*16 +: 16] = r;
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < ADV_N; k++)
            if (off == 8'(k)) rdata = regs[k*16 +: 16];
    end
endmodule

// File: rtl/vidreg_status.sv
module vidreg_status (
    input  logic clk,
    input  logic rst,
    input  logic vblank_evt,
    input  logic vb_clear,
    input  logic sel_under,
    input  logic sel_over,
    output logic vb_flag,
    output logic overscan
);
    always_ff @(posedge clk) begin
        if (rst) begin
            vb_flag  <= 1'b0;
            overscan <= 1'b0;
        end else begin
            if (vblank_evt)    vb_flag <= 1'b1;
            else if (vb_clear) vb_flag <= 1'b0;
            if (sel_over)       overscan <= 1'b1;
            else if (sel_under) overscan <= 1'b0;
        end
    end
endmodule

// File: rtl/vidreg_hostif.sv
module vidreg_hostif
    import vidreg_pkg::*;
#(
    parameter int          ADDR_W    = 12,
    parameter int          GRP_SHIFT = 10,
    parameter int          ADV_N     = 8,
    parameter logic [2:0]  VERSION   = 3'd2,
    parameter logic [3:0]  MEM_CFG   = 4'hA
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 strap_packed,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [15:0]          bus_wdata,
    output logic [15:0]          bus_rdata,
    output logic                 rd_valid,
    input  logic                 vblank_evt,
    input  logic                 field_odd,
    input  logic                 no_sync,
    input  logic                 adv_active,
    input  logic [7:0]           row_count,
    output logic [31:0]          border_color,
    output logic [7:0]           vid_ctl,
    output logic [7:0]           hue_sat,
    output logic [7:0]           ov_start,
    output logic [15:0]          wr_mask,
    output logic [7:0]           bank_lo,
    output logic [7:0]           bank_hi,
    output logic [7:0]           mode1,
    output logic [7:0]           mode2,
    output logic                 overscan,
    output logic [ADV_N*16-1:0]  adv_regs
);
    dec_t       dec;
    logic       dec_hit;
    slot_t      dec_slot;
    host_regs_t hr;
    logic [7:0] idx_q;
    logic [7:0] alias_off;
    logic       alias_hit;
    logic       adv_sel;
    logic       wr_hit, rd_hit;
    logic       adv_wr;
    logic [15:0] adv_rd;
    logic [15:0] port_rd;
    logic [15:0] rd_mux;
    logic       vb_flag;

    vidreg_decode #(.ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)) u_dec (
        .addr(bus_addr), .packed_mode(strap_packed), .dec(dec)
    );

    assign dec_hit  = dec.hit;
    assign dec_slot = dec.slot;
    assign wr_hit   = bus_wr && dec_hit;
    assign rd_hit   = bus_rd && dec_hit;
    assign adv_sel  = !hr.mode1[SEL_BIT];
    assign alias_off = idx_q - ALIAS_BASE;
    assign alias_hit = alias_off < ALIAS_N;
    assign adv_wr   = wr_hit && dec_slot == S_DATA && adv_sel && !alias_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hr    <= '0;
            idx_q <= '0;
        end else if (wr_hit) begin
            case (dec_slot)
                4'd0, 4'd1, 4'd2, 4'd3: hr.color[dec_slot[1:0]] <= bus_wdata[7:0];
                4'd4:    hr.vidctl <= bus_wdata[7:0];
                S_INDEX: idx_q     <= bus_wdata[7:0];
                4'd6:    hr.huesat <= bus_wdata[7:0];
                S_OVST:  hr.ovst   <= bus_wdata[7:0];
                S_MASKL: hr.maskl  <= bus_wdata[7:0];
                S_MASKH: hr.maskh  <= bus_wdata[7:0];
                S_BANKL: hr.bankl  <= bus_wdata[7:0];
                S_BANKH: hr.bankh  <= bus_wdata[7:0];
                S_MODE1: hr.mode1  <= bus_wdata[7:0];
                S_MODE2: hr.mode2  <= bus_wdata[7:0];
                S_DATA: begin
                    if (adv_sel && alias_hit) begin
                        if (alias_off[2]) hr.vidctl <= bus_wdata[7:0];
                        else              hr.color[alias_off[1:0]] <= bus_wdata[7:0];
                    end
                end
                default: ;
            endcase
        end
    end

    vidreg_advbank #(.ADV_N(ADV_N)) u_adv (
        .clk(clk), .rst(rst), .wr_en(adv_wr), .idx(idx_q),
        .wdata(bus_wdata), .regs(adv_regs), .rdata(adv_rd)
    );

    vidreg_status u_stat (
        .clk(clk), .rst(rst), .vblank_evt(vblank_evt),
        .vb_clear(rd_hit && dec_slot == S_STAT1),
        .sel_under(rd_hit && dec_slot == S_MASKL),
        .sel_over(rd_hit && dec_slot == S_BANKL),
        .vb_flag(vb_flag), .overscan(overscan)
    );

    always_comb begin
        if (!adv_sel)       port_rd = '0;
        else if (alias_hit) port_rd = {8'h00, alias_off[2] ? hr.vidctl : hr.color[alias_off[1:0]]};
        else                port_rd = adv_rd;
    end

    always_comb begin
        rd_mux = '0;
        if (dec_hit) begin
            case (dec_slot)
                S_STAT0:  rd_mux[7:0] = {6'b0, no_sync, field_odd};
                S_STAT1:  rd_mux[7:0] = {MEM_CFG, VERSION, vb_flag};
                S_MASKLR: rd_mux[7:0] = hr.maskl;
                S_BANKLR: rd_mux[7:0] = hr.bankl;
                S_INDEX:  rd_mux[7:0] = {4'b0, adv_active, 3'b0};
                S_MODE1R: rd_mux[7:0] = hr.mode1;
                S_OVST:   rd_mux[7:0] = hr.ovst;
                S_MASKH:  rd_mux[7:0] = hr.maskh;
                S_BANKH:  rd_mux[7:0] = hr.bankh;
                S_MODE1:  rd_mux[7:0] = row_count;
                S_MODE2:  rd_mux[7:0] = hr.mode2;
                S_DATA:   rd_mux      = port_rd;
                default:  rd_mux      = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= bus_rd;
            if (bus_rd) bus_rdata <= rd_mux;
        end
    end

    assign border_color = hr.color;
    assign vid_ctl      = hr.vidctl;
    assign hue_sat      = hr.huesat;
    assign ov_start     = hr.ovst;
    assign wr_mask      = {hr.maskh, hr.maskl};
    assign bank_lo      = hr.bankl;
    assign bank_hi      = hr.bankh;
    assign mode1        = hr.mode1;
    assign mode2        = hr.mode2;
endmodule

// File: rtl/vidreg_hostif_chk.sv
module vidreg_hostif_chk (
    input logic        clk,
    input logic        rst,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [15:0] bus_wdata,
    input logic        dec_hit,
    input logic [3:0]  dec_slot,
    input logic        rd_valid,
    input logic        vblank_evt,
    input logic        vb_flag,
    input logic        overscan,
    input logic [15:0] wr_mask
);
    // R11
    rd_valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> rd_valid);
    // R11
    rd_valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> !rd_valid);
    // R5
    vb_set_chk: assert property (@(posedge clk) disable iff (rst)
        vblank_evt |=> vb_flag);
    // R5
    vb_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec_hit && dec_slot == 4'd1 && !vblank_evt) |=> !vb_flag);
    // R6
    under_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec_hit && dec_slot == 4'd8) |=> !overscan);
    // R6
    over_sel_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec_hit && dec_slot == 4'd10) |=> overscan);
    // R6
    scan_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(bus_rd && dec_hit && (dec_slot == 4'd8 || dec_slot == 4'd10)) |=> $stable(overscan));
    // R4
    maskl_load_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && dec_hit && dec_slot == 4'd8) |=> wr_mask[7:0] == $past(bus_wdata[7:0]));
endmodule

bind vidreg_hostif vidreg_hostif_chk u_chk (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .dec_hit(dec_hit), .dec_slot(dec_slot),
    .rd_valid(rd_valid), .vblank_evt(vblank_evt), .vb_flag(vb_flag),
    .overscan(overscan), .wr_mask(wr_mask)
);

// File: tb/vidreg_hostif_tb.sv
module vidreg_hostif_tb;
    localparam int ADV_N = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         strap_packed = 1'b1;
    logic [11:0]  bus_addr = '0;
    logic         bus_rd = 1'b0, bus_wr = 1'b0;
    logic [15:0]  bus_wdata = '0;
    logic [15:0]  bus_rdata;
    logic         rd_valid;
    logic         vblank_evt = 1'b0, field_odd = 1'b0, no_sync = 1'b0, adv_active = 1'b0;
    logic [7:0]   row_count = 8'h00;
    logic [31:0]  border_color;
    logic [7:0]   vid_ctl, hue_sat, ov_start, bank_lo, bank_hi, mode1, mode2;
    logic [15:0]  wr_mask;
    logic         overscan;
    logic [ADV_N*16-1:0] adv_regs;

    int errors = 0;
    int checks = 0;
    logic [15:0] exp_q[$];
    string       req_q[$];

    always #2 clk = ~clk;

    vidreg_hostif u_dut (
        .clk(clk), .rst(rst), .strap_packed(strap_packed), .bus_addr(bus_addr),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rd_valid(rd_valid), .vblank_evt(vblank_evt),
        .field_odd(field_odd), .no_sync(no_sync), .adv_active(adv_active),
        .row_count(row_count), .border_color(border_color), .vid_ctl(vid_ctl),
        .hue_sat(hue_sat), .ov_start(ov_start), .wr_mask(wr_mask),
        .bank_lo(bank_lo), .bank_hi(bank_hi), .mode1(mode1), .mode2(mode2),
        .overscan(overscan), .adv_regs(adv_regs)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops one expected item per returned read
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) chk("R11 unexpected rd_valid", 32'(rd_valid), 32'd0);
            else begin
                string r;
                logic [15:0] e;
                r = req_q.pop_front();
                e = exp_q.pop_front();
                chk(r, 32'(bus_rdata), 32'(e));
            end
        end
    end

    function automatic logic [11:0] sa(input int s);
        logic [3:0] n;
        n = 4'(s);
        return strap_packed ? 12'(n) : {n[3:2], 8'b0, n[1:0]};
    endfunction

    task automatic wr(input logic [11:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [15:0] e, input string req, input logic vb = 1'b0);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1; vblank_evt = vb;
        exp_q.push_back(e); req_q.push_back(req);
        @(negedge clk);
        bus_rd = 1'b0; vblank_evt = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk("watchdog", 32'd1, 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        chk("R12 border", border_color, 32'h0);
        chk("R12 mask", 32'(wr_mask), 32'h0);
        chk("R12 overscan", 32'(overscan), 32'h0);
        chk("R12 adv", 32'(adv_regs[31:0]), 32'h0);
        chk("R11 idle rd_valid", 32'(rd_valid), 32'h0);
        rd(sa(1), 16'h00A4, "R12 vblank flag clear");

        // R1 packed decode of color bytes; R3 slot 0 read is status
        for (int i = 0; i < 4; i++) wr(sa(i), 16'(8'h11 * (i + 1)));
        chk("R1 border bytes", border_color, 32'h44332211);
        field_odd = 1'b1;
        rd(sa(0), 16'h0001, "R3 slot0 status odd");
        no_sync = 1'b1; field_odd = 1'b0;
        rd(sa(0), 16'h0002, "R3 slot0 status nosync");

        // R4 aliases
        wr(sa(8), 16'h005A);  rd(sa(3), 16'h005A, "R4 mask-low alias");
        wr(sa(10), 16'h0017); rd(sa(4), 16'h0017, "R4 bank-low alias");
        wr(sa(12), 16'h0001); rd(sa(6), 16'h0001, "R4 mode1 alias");
        wr(sa(9), 16'h00C3);  rd(sa(9), 16'h00C3, "R4 mask-high");
        wr(sa(7), 16'h003C);  rd(sa(7), 16'h003C, "R4 overlay start");
        row_count = 8'h77;    rd(sa(12), 16'h0077, "R4 slot12 read is row count");
        chk("R4 wr_mask", 32'(wr_mask), 32'h0000C35A);

        // R5 vblank flag
        @(negedge clk); vblank_evt = 1'b1; @(negedge clk); vblank_evt = 1'b0;
        rd(sa(1), 16'h00A5, "R5 flag set");
        rd(sa(1), 16'h00A4, "R5 flag cleared by read");
        rd(sa(1), 16'h00A4, "R5 coincident read returns old", 1'b1);
        rd(sa(1), 16'h00A5, "R5 coincident event wins");

        // R6 scan selection
        rd(sa(10), 16'h0000, "R6 overscan read data");
        chk("R6 overscan set", 32'(overscan), 32'd1);
        rd(sa(8), 16'h0000, "R6 underscan read data");
        chk("R6 underscan", 32'(overscan), 32'd0);

        // R10 advanced status
        adv_active = 1'b1; rd(sa(5), 16'h0008, "R10 adv active");
        adv_active = 1'b0; rd(sa(5), 16'h0000, "R10 adv inactive");

        // R7 R8 advanced bank
        wr(sa(5), 16'h0040); wr(sa(14), 16'hFFFF);
        rd(sa(14), 16'h07FF, "R8 slot0 width 11");
        chk("R8 adv_regs slot0", 32'(adv_regs[15:0]), 32'h07FF);
        wr(sa(5), 16'h0041); wr(sa(14), 16'hFFFF);
        rd(sa(14), 16'h01FF, "R8 slot1 width 9");
        wr(sa(5), 16'h0042); wr(sa(14), 16'hBEEF);
        rd(sa(14), 16'hBEEF, "R7 slot2 data port");
        chk("R7 adv_regs slot2", 32'(adv_regs[47:32]), 32'hBEEF);

        // R9 aliases into host registers
        wr(sa(5), 16'h00E1); wr(sa(14), 16'h1299);
        chk("R9 color byte1", border_color, 32'h44339911);
        rd(sa(14), 16'h0099, "R9 E1 readback");
        wr(sa(5), 16'h00E4); wr(sa(14), 16'hAB5C);
        chk("R9 vidctl", 32'(vid_ctl), 32'h5C);

        // R7 selector bit set: data port inert
        wr(sa(12), 16'h0041); wr(sa(5), 16'h0042); wr(sa(14), 16'h1234);
        rd(sa(14), 16'h0000, "R7 std select read zero");
        chk("R7 std select no write", 32'(adv_regs[47:32]), 32'hBEEF);
        wr(sa(12), 16'h0001);
        rd(sa(14), 16'hBEEF, "R7 adv select restored");

        // R2 sparse decode
        @(negedge clk); strap_packed = 1'b0;
        wr(12'h801, 16'h0066); rd(12'h801, 16'h0066, "R2 sparse slot9");
        chk("R2 sparse mask-high", 32'(wr_mask[15:8]), 32'h66);
        wr(12'h009, 16'h0011); rd(12'h801, 16'h0066, "R2 sparse miss write ignored");
        rd(12'h009, 16'h0000, "R2 sparse miss read");
        rd(12'h402, 16'h0001, "R2 sparse slot6");

        // R1 packed miss
        @(negedge clk); strap_packed = 1'b1;
        wr(12'h408, 16'h00EE);
        chk("R1 packed miss write ignored", 32'(wr_mask[7:0]), 32'h5A);
        rd(12'h400, 16'h0000, "R1 packed miss read");

        repeat (3) @(negedge clk);
        chk("R11 queue drained", 32'(exp_q.size()), 32'd0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule